// File: doc/BRIEF.md
# Byte-Wide SPI Serial Port

This block is an 8-bit SPI peripheral that a host reaches through four byte-wide registers. It works in one of two roles. As a master it produces the serial clock from the system clock, divided by 4, 16 or 64. As a slave it follows a serial clock that comes in from outside, and it can optionally be framed by an active-low select.

Every transfer moves eight bits, most significant bit first. When a transfer completes, the received byte is placed in a single-byte holding buffer and a completion flag is raised. That flag drives the interrupt output.

The host controls several timing choices:
- the idle level of the clock;
- whether the first clock edge of a bit comes at the start of the bit or in its middle;
- whether the master samples input data at mid-bit or at the end of the bit.

A halt input models a low-power state. It freezes the master in place. A slave keeps receiving through it, so the flag it raises can serve as a wake request.

Top module: `spi_port`

## Requirements
- R1: After reset every register reads 0, `irq` is 0, `sck_out` is 0 and `sdo_oe` is 0. The register map is:
  - address 0: data buffer;
  - address 1: control, with bit7 collision, bit6 overflow, bit5 enable, bit4 clock idle level and bits3:0 role select;
  - address 2: timing, with bit7 sample-late, bit6 edge-select and bit0 buffer-full (read only);
  - address 3: bit0 completion flag.
- R2: With enable set and a master role selected, writing address 0 while idle starts a transfer. `sdo` sends the byte MSB first and `sdi` is shifted in MSB first. At the end the received byte is in the buffer, and buffer-full and the flag (and so `irq`) are 1.
- R3: Role select 0000, 0001 and 0010 give an SCK period of 4, 16 and 64 system clocks. `irq` rises exactly 8 SCK periods after the clock edge that takes the start write.
- R4: `sck_out` rests at the idle-level bit. With edge-select 1 the clock leaves idle in the middle of each bit; with edge-select 0 it leaves idle at the start of each bit. In both cases `sdo` changes at the start of a bit.
- R5: With sample-late 0 the master samples `sdi` at mid-bit; with sample-late 1 it samples at the end of the bit.
- R6: While `halt` is 1 a master transfer freezes. It resumes at the same bit position, so each halted cycle lengthens the transfer by one cycle and the data is unchanged.
- R7: Role select 0100 or 0101 makes the block a slave clocked by `sck_in`, with the same edge-select meaning as R4. After eight sampling edges it sets the buffer and the flag, and `halt` has no effect on it.
- R8: In role 0100, `ss_n` high forces `sdo_oe` to 0 and clears the bit count, so a partial byte is dropped. Role 0101 ignores `ss_n` and always drives `sdo`.
- R9: A data write while a byte is in progress is ignored and sets the collision bit. The bit stays set until the host writes it to 0.
- R10: A byte that completes while buffer-full is 1 is discarded. The overflow bit is set and the buffer keeps its old byte.
- R11: Reading address 0 clears buffer-full. Writing 0 to address 3 clears the flag and `irq`.
- R12: With enable 0, a data write starts nothing: no flag, no buffer-full, and SCK stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Low-power halt; freezes master activity |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (address 0 read clears buffer-full) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| irq | output | 1 | Completion flag |
| sck_out | output | 1 | Serial clock driven in master role |
| sck_in | input | 1 | Serial clock received in slave role |
| ss_n | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |

## Verification
The hardest case to reach from the ports is the difference between sampling at mid-bit and sampling at end of bit, since a well-behaved remote device holds `sdi` steady across the whole bit. The bench's remote model can run in a split mode: it drives one bit value in the first half of every bit and a different value in the second half, so the received byte shows directly which sample point was used. A slave byte that is cut short by select, and then followed by a clean byte, is driven explicitly. This shows that the leftover bits never reach the buffer.

// File: rtl/spi_pkg.sv
package spi_pkg;

  typedef enum logic [1:0] {
    ROLE_OFF   = 2'd0,
    ROLE_MST   = 2'd1,
    ROLE_SLV_S = 2'd2,
    ROLE_SLV_F = 2'd3
  } role_e;

  // half SCK period, in system clocks, per divider choice
  localparam int unsigned HALF_D4  = 2;
  localparam int unsigned HALF_D16 = 8;
  localparam int unsigned HALF_D64 = 32;

  function automatic role_e decode_role(input logic [3:0] sel);
    case (sel)
      4'b0000, 4'b0001, 4'b0010: decode_role = ROLE_MST;
      4'b0100:                   decode_role = ROLE_SLV_S;
      4'b0101:                   decode_role = ROLE_SLV_F;
      default:                   decode_role = ROLE_OFF;
    endcase
  endfunction

  function automatic int unsigned half_clocks(input logic [1:0] sel);
    case (sel)
      2'b00:   half_clocks = HALF_D4;
      2'b01:   half_clocks = HALF_D16;
      default: half_clocks = HALF_D64;
    endcase
  endfunction

endpackage

// File: rtl/spi_mst.sv
module spi_mst
  import spi_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          halt,
  input  logic          start,
  input  logic [DW-1:0] tx_data,
  input  logic [1:0]    div_sel,
  input  logic          cpol,
  input  logic          cke,
  input  logic          smp,
  input  logic          sdi,
  output logic          sck,
  output logic          sdo,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_byte
);
  localparam int HW   = $clog2(HALF_D64 + 1);
  localparam int HC_W = $clog2(2 * DW);

  function automatic logic [DW-1:0] push_bit(input logic [DW-1:0] v, input logic b);
    return {v[DW-2:0], b};
  endfunction

  logic [HW-1:0]   dcnt;
  logic [HC_W-1:0] hidx;
  logic [DW-1:0]   tx_sr, rx_sr;

  wire [HW-1:0] half      = HW'(half_clocks(div_sel));
  wire          odd       = hidx[0];
  wire          last_half = (hidx == HC_W'(2 * DW - 1));
  wire          half_end  = busy && !halt && (dcnt >= half - 1'b1);
  wire          take      = half_end && (odd == smp);
  wire [DW-1:0] rx_next   = take ? push_bit(rx_sr, sdi) : rx_sr;

  assign done    = half_end && last_half;
  assign rx_byte = rx_next;
  assign sdo     = tx_sr[DW-1];
  assign sck     = cpol ^ (busy && (odd == cke));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      dcnt  <= '0;
      hidx  <= '0;
      tx_sr <= '0;
      rx_sr <= '0;
    end else if (!run) begin
      busy <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        dcnt  <= '0;
        hidx  <= '0;
        tx_sr <= tx_data;
      end
    end else if (!halt) begin
      if (half_end) begin
        dcnt  <= '0;
        hidx  <= hidx + 1'b1;
        rx_sr <= rx_next;
        if (odd) begin
          if (last_half) busy <= 1'b0;
          else           tx_sr <= tx_sr << 1;
        end
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end

  // R6: a halted transfer keeps its position and outgoing data
  a_r6_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && halt && run) |=> ($stable(hidx) && $stable(dcnt) && $stable(tx_sr)));

endmodule

// File: rtl/spi_slv.sv
module spi_slv #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          use_sel,
  input  logic          sck_in,
  input  logic          ss_n,
  input  logic          sdi,
  input  logic          cpol,
  input  logic          cke,
  input  logic          load,
  input  logic [DW-1:0] tx_data,
  output logic          sdo,
  output logic          sdo_oe,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_byte
);
  localparam int CW = $clog2(DW);

  function automatic logic [DW-1:0] push_bit(input logic [DW-1:0] v, input logic b);
    return {v[DW-2:0], b};
  endfunction

  logic [2:0]    sck_sy;
  logic [1:0]    ss_sy;
  logic [CW-1:0] cnt;
  logic [DW-1:0] tx_sr, rx_sr;

  wire lvl_act  = sck_sy[1] ^ cpol;
  wire prv_act  = sck_sy[2] ^ cpol;
  wire lead     = lvl_act && !prv_act;
  wire trail    = !lvl_act && prv_act;
  wire desel    = use_sel && ss_sy[1];
  wire active   = run && !desel;
  wire smp_edge = active && (cke ? lead : trail);
  wire chg_edge = active && (cke ? trail : lead);
  wire last_bit = (cnt == CW'(DW - 1));

  assign rx_byte = push_bit(rx_sr, sdi);
  assign done    = smp_edge && last_bit;
  assign busy    = (cnt != '0);
  assign sdo     = tx_sr[DW-1];
  assign sdo_oe  = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '0;
      ss_sy  <= '1;
      cnt    <= '0;
      tx_sr  <= '0;
      rx_sr  <= '0;
    end else begin
      sck_sy <= {sck_sy[1:0], sck_in};
      ss_sy  <= {ss_sy[0], ss_n};
      if (load)                         tx_sr <= tx_data;
      else if (chg_edge && cnt != '0)   tx_sr <= tx_sr << 1;
      if (!active) begin
        cnt <= '0;
      end else if (smp_edge) begin
        rx_sr <= rx_byte;
        cnt   <= last_bit ? '0 : cnt + 1'b1;
      end
    end
  end

  // R8: a deselect (synchronised) always leaves the bit count at zero
  a_r8_desel_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (use_sel && $past(ss_sy[1]) && ss_sy[1]) |-> (cnt == '0));

endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          sck_out,
  input  logic          sck_in,
  input  logic          ss_n,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe
);
  logic [DW-1:0] data_buf;
  logic          wcol, ovf, en, cpol, smp, cke, bf, flag;
  logic [3:0]    role_sel;

  role_e role;
  assign role = decode_role(role_sel);

  wire mst_on = en && (role == ROLE_MST);
  wire slv_on = en && (role == ROLE_SLV_S || role == ROLE_SLV_F);

  logic          mst_busy, mst_done, mst_sck, mst_sdo;
  logic          slv_busy, slv_done, slv_sdo, slv_oe;
  logic [DW-1:0] mst_rx, slv_rx;

  wire in_prog = mst_busy || slv_busy;
  wire wr_buf  = bus_wr && (bus_addr == 2'd0);
  wire rd_buf  = bus_rd && (bus_addr == 2'd0);
  wire accept  = wr_buf && (mst_on || slv_on) && !in_prog;
  wire collide = wr_buf && (mst_on || slv_on) && in_prog;
  wire done    = mst_done || slv_done;
  wire [DW-1:0] rx_any = mst_done ? mst_rx : slv_rx;

  spi_mst #(.DW(DW)) u_mst (
    .clk(clk), .rst_n(rst_n), .run(mst_on), .halt(halt),
    .start(accept && mst_on), .tx_data(bus_wdata), .div_sel(role_sel[1:0]),
    .cpol(cpol), .cke(cke), .smp(smp), .sdi(sdi),
    .sck(mst_sck), .sdo(mst_sdo), .busy(mst_busy), .done(mst_done), .rx_byte(mst_rx)
  );

  spi_slv #(.DW(DW)) u_slv (
    .clk(clk), .rst_n(rst_n), .run(slv_on), .use_sel(role == ROLE_SLV_S),
    .sck_in(sck_in), .ss_n(ss_n), .sdi(sdi), .cpol(cpol), .cke(cke),
    .load(accept && slv_on), .tx_data(bus_wdata),
    .sdo(slv_sdo), .sdo_oe(slv_oe), .busy(slv_busy), .done(slv_done), .rx_byte(slv_rx)
  );

  assign sck_out = mst_sck;
  assign sdo     = slv_on ? slv_sdo : mst_sdo;
  assign sdo_oe  = mst_on || slv_oe;
  assign irq     = flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_buf <= '0;
      {wcol, ovf, en, cpol, role_sel} <= '0;
      {smp, cke, bf, flag} <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          2'd1: {wcol, ovf, en, cpol, role_sel} <= bus_wdata[7:0];
          2'd2: {smp, cke} <= bus_wdata[7:6];
          2'd3: flag <= bus_wdata[0];
          default: ;
        endcase
      end
      if (collide) wcol <= 1'b1;
      if (rd_buf)  bf <= 1'b0;
      if (done) begin
        flag <= 1'b1;
        if (bf) ovf <= 1'b1;
        else begin
          data_buf <= rx_any;
          bf       <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = data_buf;
      2'd1:    bus_rdata = DW'({wcol, ovf, en, cpol, role_sel});
      2'd2:    bus_rdata = DW'({smp, cke, 5'b00000, bf});
      default: bus_rdata = DW'(flag);
    endcase
  end

  // R2: a byte completing into an empty buffer fills it and raises the flag
  a_r2_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !bf) |=> (bf && flag));

  // R9: a data write during a byte sets the collision bit
  a_r9_collision: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> wcol);

  // R10: a byte completing into a full buffer is dropped and flagged
  a_r10_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bf) |=> (ovf && data_buf == $past(data_buf)));

  // R11: a buffer read with no completion in the same cycle empties it
  a_r11_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_buf && !done) |=> !bf);

  // R12: no output drive while disabled
  a_r12_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !sdo_oe);

endmodule

// File: tb/tb_spi_port.sv
module tb_spi_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       halt = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, sck_out, sdo, sdo_oe;
  logic       sck_in = 1'b0, ss_n = 1'b1, sdi = 1'b0;

  int n_run = 0, n_fail = 0;

  spi_port dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // remote device model for master transfers
  logic       cpol_t = 1'b0, cke_t = 1'b1;
  logic [7:0] rem_a, rem_b, rem_cap;
  bit         rem_split = 1'b0, rem_on = 1'b0;
  int         rem_bit;
  logic [7:0] sb_q[$];

  always @(sck_out) if (rem_on) begin
    if ((sck_out ^ cpol_t) == 1'b1) begin
      if (cke_t) begin
        rem_cap = {rem_cap[6:0], sdo};
        if (rem_split && rem_bit < 8) sdi = rem_b[7-rem_bit];
      end else if (rem_bit < 8) sdi = rem_a[7-rem_bit];
    end else begin
      if (cke_t) begin
        rem_bit++;
        if (rem_bit < 8) sdi = rem_a[7-rem_bit];
      end else begin
        rem_cap = {rem_cap[6:0], sdo};
        if (rem_split && rem_bit < 8) sdi = rem_b[7-rem_bit];
        rem_bit++;
      end
    end
  end

  // scoreboard monitor: remote side must have received the queued byte
  always @(posedge irq) if (rem_on) begin
    logic [7:0] e;
    @(negedge clk);
    if (sb_q.size() == 0) chk(1'b0, "R2 remote byte (queue empty)", rem_cap, 0);
    else begin
      e = sb_q.pop_front();
      chk(rem_cap == e, "R2 remote byte", rem_cap, e);
    end
  end

  task automatic mxfer(input logic [7:0] tx, input logic [7:0] ra, input logic [7:0] rb,
                       input bit split, input logic [7:0] exp_rx, input int exp_n,
                       input int halt_at, input int halt_len, input bit coll,
                       input bit do_read, input string tag);
    int n;
    logic [7:0] v;
    rem_a = ra; rem_b = rb; rem_split = split; rem_bit = 0; rem_cap = '0;
    sdi = ra[7]; rem_on = 1'b1;
    sb_q.push_back(tx);
    wr(2'd0, tx);
    // wr returns at the negedge after the start edge
    chk(sck_out == (cpol_t ^ ~cke_t), {tag, " R4 first half level"}, sck_out, cpol_t ^ ~cke_t);
    n = 0;
    while (!irq && n < 3000) begin
      @(negedge clk);
      n++;
      if (halt_len > 0 && n == halt_at) halt = 1'b1;
      if (halt_len > 0 && n == halt_at + halt_len) halt = 1'b0;
      if (coll && n == 10) begin bus_addr = 2'd0; bus_wdata = 8'hFF; bus_wr = 1'b1; end
      if (coll && n == 11) bus_wr = 1'b0;
    end
    chk(n == exp_n, {tag, " R3 cycles to irq"}, n, exp_n);
    chk(sck_out == cpol_t, {tag, " R4 idle level after"}, sck_out, cpol_t);
    @(negedge clk);
    if (do_read) begin
      rd(2'd0, v);
      chk(v == exp_rx, {tag, " R2 received byte"}, v, exp_rx);
    end
    wr(2'd3, 8'h00);
    rem_on = 1'b0;
  endtask

  // bench acts as master toward the slave role
  task automatic sbits(input logic [7:0] tx, input int nb, output logic [7:0] cap);
    cap = '0;
    for (int i = 0; i < nb; i++) begin
      sdi = tx[7-i];
      if (!cke_t) sck_in = ~cpol_t;
      repeat (6) @(negedge clk);
      cap = {cap[6:0], sdo};
      sck_in = cke_t ? ~cpol_t : cpol_t;
      repeat (6) @(negedge clk);
      if (cke_t) begin sck_in = cpol_t; repeat (6) @(negedge clk); end
    end
    repeat (6) @(negedge clk);
  endtask

  logic [7:0] v, cap;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(sck_out == 1'b0, "R1 sck_out", sck_out, 0);
    chk(sdo_oe == 1'b0, "R1 sdo_oe", sdo_oe, 0);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk(v == 8'h00, "R1 register zero", v, 0);
    end

    // R12 disabled: write starts nothing
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h5A);
    begin
      bit moved = 1'b0;
      for (int i = 0; i < 80; i++) begin @(negedge clk); if (sck_out) moved = 1'b1; end
      chk(!moved, "R12 sck stays idle", moved, 0);
    end
    chk(irq == 1'b0, "R12 no flag", irq, 0);
    rd(2'd2, v);
    chk(v[0] == 1'b0, "R12 no buffer-full", v[0], 0);

    // master div4, idle low, edge-select 1, mid sample
    cpol_t = 0; cke_t = 1;
    wr(2'd2, 8'h40); wr(2'd1, 8'h20);
    chk(sdo_oe == 1'b1, "R2 master drives sdo", sdo_oe, 1);
    mxfer(8'hA5, 8'h3C, 8'h00, 0, 8'h3C, 32, 0, 0, 0, 1, "m4");

    // div16, idle high, edge-select 0
    cpol_t = 1; cke_t = 0;
    wr(2'd2, 8'h00); wr(2'd1, 8'h31);
    chk(sck_out == 1'b1, "R4 idle high", sck_out, 1);
    mxfer(8'h96, 8'hE1, 8'h00, 0, 8'hE1, 128, 0, 0, 0, 1, "m16");

    // R5 sample point, split remote data
    cpol_t = 0; cke_t = 1;
    wr(2'd1, 8'h20); wr(2'd2, 8'hC0);
    mxfer(8'h5B, 8'h0F, 8'hF0, 1, 8'hF0, 32, 0, 0, 0, 1, "R5 late");
    wr(2'd2, 8'h40);
    mxfer(8'h5B, 8'h0F, 8'hF0, 1, 8'h0F, 32, 0, 0, 0, 1, "R5 mid");
    cke_t = 0;
    wr(2'd2, 8'h80);
    mxfer(8'hC6, 8'h33, 8'hCC, 1, 8'hCC, 32, 0, 0, 0, 1, "R5 late e0");

    // div64, edge-select 0, late sample
    wr(2'd1, 8'h22);
    mxfer(8'h3B, 8'hC4, 8'h00, 0, 8'hC4, 512, 0, 0, 0, 1, "m64");

    // R6 halt mid-transfer
    cke_t = 1;
    wr(2'd2, 8'h40); wr(2'd1, 8'h20);
    mxfer(8'h6E, 8'h9D, 8'h00, 0, 8'h9D, 72, 5, 40, 0, 1, "R6 halt");

    // R9 collision
    mxfer(8'h24, 8'h81, 8'h00, 0, 8'h81, 32, 0, 0, 1, 1, "R9 coll");
    rd(2'd1, v);
    chk(v[7] == 1'b1, "R9 collision bit set", v[7], 1);
    wr(2'd1, 8'h20);
    rd(2'd1, v);
    chk(v[7] == 1'b0, "R9 collision cleared by write", v[7], 0);

    // R10 overflow, R11 read clear
    mxfer(8'h11, 8'h11, 8'h00, 0, 8'h11, 32, 0, 0, 0, 0, "R10 first");
    mxfer(8'h22, 8'h22, 8'h00, 0, 8'h22, 32, 0, 0, 0, 0, "R10 second");
    rd(2'd1, v);
    chk(v[6] == 1'b1, "R10 overflow bit", v[6], 1);
    rd(2'd0, v);
    chk(v == 8'h11, "R10 old byte kept", v, 8'h11);
    rd(2'd2, v);
    chk(v[0] == 1'b0, "R11 buffer-full cleared by read", v[0], 0);
    chk(irq == 1'b0, "R11 flag cleared by write", irq, 0);

    // R7 slave free role, halt held, edge-select 1
    wr(2'd1, 8'h00);
    cpol_t = 0; cke_t = 1; sck_in = 1'b0;
    wr(2'd2, 8'h40); wr(2'd1, 8'h25);
    wr(2'd0, 8'hC3);
    chk(sdo_oe == 1'b1, "R8 free role drives with ss_n high", sdo_oe, 1);
    halt = 1'b1;
    sbits(8'h5E, 8, cap);
    halt = 1'b0;
    chk(irq == 1'b1, "R7 slave flag despite halt", irq, 1);
    chk(cap == 8'hC3, "R7 slave sent byte", cap, 8'hC3);
    rd(2'd0, v);
    chk(v == 8'h5E, "R7 slave received byte", v, 8'h5E);
    wr(2'd3, 8'h00);

    // R7 slave, idle high, edge-select 0
    wr(2'd1, 8'h00);
    cpol_t = 1; cke_t = 0; sck_in = 1'b1;
    repeat (4) @(negedge clk);
    wr(2'd2, 8'h00); wr(2'd1, 8'h35);
    wr(2'd0, 8'h7E);
    sbits(8'h81, 8, cap);
    chk(cap == 8'h7E, "R7 slave e0 sent byte", cap, 8'h7E);
    rd(2'd0, v);
    chk(v == 8'h81, "R7 slave e0 received byte", v, 8'h81);
    wr(2'd3, 8'h00);

    // R8 select framing
    wr(2'd1, 8'h00);
    cpol_t = 0; cke_t = 1; sck_in = 1'b0; ss_n = 1'b1;
    repeat (4) @(negedge clk);
    wr(2'd2, 8'h40); wr(2'd1, 8'h24);
    repeat (3) @(negedge clk);
    chk(sdo_oe == 1'b0, "R8 tri-state while deselected", sdo_oe, 0);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(sdo_oe == 1'b1, "R8 drive while selected", sdo_oe, 1);
    sbits(8'hFF, 3, cap);
    ss_n = 1'b1;
    repeat (6) @(negedge clk);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(irq == 1'b0, "R8 partial byte dropped", irq, 0);
    wr(2'd0, 8'h99);
    sbits(8'h4D, 8, cap);
    chk(cap == 8'h99, "R8 sent byte after restart", cap, 8'h99);
    rd(2'd0, v);
    chk(v == 8'h4D, "R8 clean byte after restart", v, 8'h4D);
    ss_n = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule